// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the status byte of a serial memory device and rules on every write request before it reaches the storage array or the status bits. It takes already-decoded command strobes from the serial front end. These are: set write enable, clear write enable (which also clears the user flag), set flag, and status write with its data byte. It also takes the level of the active-low write-protect pin, start and end pulses from the self-timed programming engine, and the byte address of any pending array write. From these it produces a status byte for readback and two single-cycle grant signals, one for array writes and one for status writes.

Two independent guards are applied. A two-bit zone code protects the upper quarter, the upper half or the whole of a 4 KiB array. A lock bit works together with the write-protect pin to freeze the status register: once the lock bit is committed while the pin is held low, the register can only change after the pin is released. The lock bit and the zone code stand in for nonvolatile cells. They are registers, loaded through a load strobe during boot and updated when a granted status write finishes its programming cycle.

Top module: `wp_status_unit`

## Requirements
- R1: The status byte is {lock, flag, 1, 1, zone[1], zone[0], wel, wip} from bit 7 down to bit 0. Bits 5 and 4 always read 1.
- R2: After reset the status byte reads 8'h30, with lock and zone also cleared. A set-enable strobe makes wel read 1 in the following cycle.
- R3: A set-flag strobe makes flag (bit 6) read 1. A clear-enable strobe clears both wel and flag in the same cycle. If set-flag and clear-enable arrive together, the clear wins.
- R4: wip reads 1 from the cycle after a start pulse until the cycle after the end pulse, and the status byte stays readable throughout.
- R5: An end pulse clears wel. If a set-enable strobe arrives in the same cycle as the end pulse, wel ends up 1.
- R6: With the default 12-bit address, zone 00 protects nothing, 01 protects 0xC00..0xFFF, 10 protects 0x800..0xFFF and 11 protects 0x000..0xFFF. A write to a protected address is never granted.
- R7: An array write is granted only when wel is 1, no programming cycle is running (wip 0) and no granted status write is still waiting for its end pulse.
- R8: A status write is refused while lock is 1 and the write-protect pin is low. When lock is 0 the pin level has no effect on status writes.
- R9: A status write is granted only with wel 1 and no cycle running or pending. Its lock and zone values are committed at the next end pulse, even if the write-protect pin falls in between.
- R10: Only bits 7, 3 and 2 of the written status data are stored. Bits 6, 5, 4, 1 and 0 of the written data have no effect on the status byte.
- R11: A load strobe sets lock and zone directly from the load inputs. This takes priority over a commit in the same cycle.
- R12: A refused array or status write changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wen_set | input | 1 | Strobe: set write enable |
| cmd_wen_clr | input | 1 | Strobe: clear write enable and flag |
| cmd_flag_set | input | 1 | Strobe: set user flag |
| cmd_sts_wr | input | 1 | Strobe: status write request |
| sts_wdata | input | 8 | Data for a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| cyc_start | input | 1 | Programming cycle start pulse |
| cyc_end | input | 1 | Programming cycle end pulse |
| arr_wr_req | input | 1 | Array write request |
| arr_addr | input | ADDR_W | Target byte address of the array write |
| nv_ld | input | 1 | Load strobe for lock and zone |
| nv_ld_lock | input | 1 | Lock value to load |
| nv_ld_zone | input | 2 | Zone code to load |
| status | output | 8 | Status byte |
| arr_grant | output | 1 | Array write granted (combinational) |
| sts_grant | output | 1 | Status write granted (combinational) |

## Verification
Two events can land on the same clock edge: the end of a programming cycle, which clears write enable, and a fresh set-enable or clear-enable strobe. The bench places a set-enable strobe on the exact edge that carries the end pulse, and in another run a clear-enable strobe on that edge, then reads wel in the next cycle. It expects 1 in the first case and 0 in the second. It also drops the write-protect pin while a granted status write is waiting for its end pulse, and confirms that the new lock and zone values still appear once the pulse arrives.

// File: rtl/wp_status_unit.sv
module wp_status_unit #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wen_set,
  input  logic              cmd_wen_clr,
  input  logic              cmd_flag_set,
  input  logic              cmd_sts_wr,
  input  logic [7:0]        sts_wdata,
  input  logic              wp_n,
  input  logic              cyc_start,
  input  logic              cyc_end,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              nv_ld,
  input  logic              nv_ld_lock,
  input  logic [1:0]        nv_ld_zone,
  output logic [7:0]        status,
  output logic              arr_grant,
  output logic              sts_grant
);
  logic       wel, flag, wip, lock, pend, p_lock;
  logic [1:0] zone, p_zone;
  logic [1:0] top;
  logic       busy, prot, frozen;

  assign top    = arr_addr[ADDR_W-1 -: 2];
  assign busy   = wip | pend;
  assign prot   = (zone == 2'b11) | ((zone == 2'b10) & top[1]) | ((zone == 2'b01) & (&top));
  assign frozen = lock & ~wp_n;

  assign arr_grant = arr_wr_req & wel & ~busy & ~prot;
  assign sts_grant = cmd_sts_wr & wel & ~busy & ~frozen;
  assign status    = {lock, flag, 2'b11, zone, wel, wip};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      flag   <= 1'b0;
      wip    <= 1'b0;
      pend   <= 1'b0;
      p_lock <= 1'b0;
      p_zone <= 2'b00;
      lock   <= 1'b0;
      zone   <= 2'b00;
    end else begin
      if (cmd_wen_set)               wel <= 1'b1;
      else if (cmd_wen_clr | cyc_end) wel <= 1'b0;

      if (cmd_wen_clr)       flag <= 1'b0;
      else if (cmd_flag_set) flag <= 1'b1;

      if (cyc_start)    wip <= 1'b1;
      else if (cyc_end) wip <= 1'b0;

      if (nv_ld) begin
        lock <= nv_ld_lock;
        zone <= nv_ld_zone;
      end else if (cyc_end & pend) begin
        lock <= p_lock;
        zone <= p_zone;
      end

      if (sts_grant) begin
        pend   <= 1'b1;
        p_lock <= sts_wdata[7];
        p_zone <= sts_wdata[3:2];
      end else if (cyc_end) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

module wp_status_unit_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wen_set,
  input logic              cmd_wen_clr,
  input logic              cmd_flag_set,
  input logic              cyc_start,
  input logic              cyc_end,
  input logic              wp_n,
  input logic              nv_ld,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [7:0]        status,
  input logic              arr_grant,
  input logic              sts_grant
);
  p_const_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[5:4] == 2'b11);
  p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wen_set |=> status[1]);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wen_clr && !cmd_wen_set) |=> (!status[1] && !status[6]));
  p_wip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> status[0]);
  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !cyc_start && !cmd_wen_set) |=> (!status[1] && !status[0]));
  p_all_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !arr_grant);
  p_arr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> (status[1] && !status[0]));
  p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && status[7]) |-> !sts_grant);
  p_sts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_grant |-> (status[1] && !status[0]));
  p_nv_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_ld && !cyc_end) |=> $stable({status[7], status[3:2]}));
endmodule

bind wp_status_unit wp_status_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wen_set(cmd_wen_set), .cmd_wen_clr(cmd_wen_clr),
  .cmd_flag_set(cmd_flag_set), .cyc_start(cyc_start), .cyc_end(cyc_end),
  .wp_n(wp_n), .nv_ld(nv_ld), .arr_addr(arr_addr), .status(status),
  .arr_grant(arr_grant), .sts_grant(sts_grant)
);

// File: tb/sim_wp_status_unit.sv
`timescale 1ns/1ps
module sim_wp_status_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wen_set = 0, cmd_wen_clr = 0, cmd_flag_set = 0, cmd_sts_wr = 0;
  logic [7:0] sts_wdata = 8'h00;
  logic wp_n = 1'b1, cyc_start = 0, cyc_end = 0, arr_wr_req = 0;
  logic [11:0] arr_addr = 12'h000;
  logic nv_ld = 0, nv_ld_lock = 0;
  logic [1:0] nv_ld_zone = 2'b00;
  logic [7:0] status;
  logic arr_grant, sts_grant;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  wp_status_unit u0 (.clk, .rst_n, .cmd_wen_set, .cmd_wen_clr, .cmd_flag_set,
    .cmd_sts_wr, .sts_wdata, .wp_n, .cyc_start, .cyc_end, .arr_wr_req, .arr_addr,
    .nv_ld, .nv_ld_lock, .nv_ld_zone, .status, .arr_grant, .sts_grant);

  // behavioural reference
  bit m_wel, m_flag, m_wip, m_lock, m_pend, m_plock;
  int m_zone, m_pzone;

  function automatic bit prot_f(int z, int a);
    if (z == 0) return 0;
    if (z == 1) return a >= 'hC00;
    if (z == 2) return a >= 'h800;
    return 1;
  endfunction

  function automatic bit e_arr();
    return arr_wr_req && m_wel && !(m_wip || m_pend) && !prot_f(m_zone, arr_addr);
  endfunction
  function automatic bit e_sts();
    return cmd_sts_wr && m_wel && !(m_wip || m_pend) && !(m_lock && !wp_n);
  endfunction
  function automatic logic [7:0] e_status();
    logic [1:0] z = m_zone[1:0];
    return {m_lock, m_flag, 2'b11, z, m_wel, m_wip};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wel = 0; m_flag = 0; m_wip = 0; m_lock = 0; m_pend = 0; m_plock = 0;
      m_zone = 0; m_pzone = 0;
    end else begin
      bit g;
      g = e_sts();
      if (nv_ld) begin m_lock = nv_ld_lock; m_zone = nv_ld_zone; end
      else if (cyc_end && m_pend) begin m_lock = m_plock; m_zone = m_pzone; end
      if (g) begin m_pend = 1; m_plock = sts_wdata[7]; m_pzone = sts_wdata[3:2]; end
      else if (cyc_end) m_pend = 0;
      if (cmd_wen_set) m_wel = 1; else if (cmd_wen_clr || cyc_end) m_wel = 0;
      if (cmd_wen_clr) m_flag = 0; else if (cmd_flag_set) m_flag = 1;
      if (cyc_start) m_wip = 1; else if (cyc_end) m_wip = 0;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [7:0] es;
    es = e_status();
    chk("R1 R2 R3 R4 status model", status, es);
    chk("R6 R7 arr_grant model", {7'd0, arr_grant}, {7'd0, e_arr()});
    chk("R8 R9 sts_grant model", {7'd0, sts_grant}, {7'd0, e_sts()});
  end

  task automatic tick();
    @(posedge clk); #1;
    cmd_wen_set = 0; cmd_wen_clr = 0; cmd_flag_set = 0; cmd_sts_wr = 0;
    cyc_start = 0; cyc_end = 0; arr_wr_req = 0; nv_ld = 0;
    #1;
  endtask

  task automatic load(bit l, logic [1:0] z);
    nv_ld = 1; nv_ld_lock = l; nv_ld_zone = z; tick();
  endtask

  task automatic try_arr(string tag, logic [11:0] a, bit exp);
    arr_addr = a; arr_wr_req = 1; #0.5;
    chk(tag, {7'd0, arr_grant}, {7'd0, exp});
    tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    chk("R2 reset status", status, 8'h30);
    cmd_wen_set = 1; tick();
    chk("R2 wel set", status, 8'h32);
    cmd_flag_set = 1; tick();
    chk("R3 flag set", status, 8'h72);
    cmd_wen_clr = 1; tick();
    chk("R3 clear both", status, 8'h30);
    cmd_flag_set = 1; cmd_wen_clr = 1; tick();
    chk("R3 clear wins over set", status, 8'h30);

    try_arr("R7 refused without wel", 12'h000, 0);
    chk("R12 refused arr no change", status, 8'h30);
    cmd_wen_set = 1; tick();
    for (int z = 0; z < 4; z++) begin
      load(0, z[1:0]);
      try_arr("R6 addr 0x000", 12'h000, z != 3);
      try_arr("R6 addr 0x7FF", 12'h7FF, z != 3);
      try_arr("R6 addr 0x800", 12'h800, z < 2);
      try_arr("R6 addr 0xBFF", 12'hBFF, z < 2);
      try_arr("R6 addr 0xC00", 12'hC00, z == 0);
      try_arr("R6 addr 0xFFF", 12'hFFF, z == 0);
    end
    chk("R11 load zone 11", status, 8'h3E);
    load(0, 2'b00);

    try_arr("R7 granted", 12'h123, 1);
    cyc_start = 1; tick();
    chk("R4 wip set", status, 8'h33);
    try_arr("R7 refused while wip", 12'h124, 0);
    repeat (3) tick();
    chk("R4 status readable in cycle", status, 8'h33);
    cyc_end = 1; tick();
    chk("R5 end clears wel and wip", status, 8'h30);

    cmd_wen_set = 1; tick();
    cmd_sts_wr = 1; sts_wdata = 8'hF3; #0.5;
    chk("R9 status write granted", {7'd0, sts_grant}, 8'd1);
    tick();
    try_arr("R7 refused while pending", 12'h000, 0);
    cyc_start = 1; tick();
    wp_n = 0; tick(); tick();
    cyc_end = 1; tick();
    chk("R9 R10 committed despite pin", status, 8'hB0);

    cmd_wen_set = 1; tick();
    cmd_sts_wr = 1; sts_wdata = 8'h0C; #0.5;
    chk("R8 locked refused", {7'd0, sts_grant}, 8'd0);
    tick();
    chk("R12 refused sts no change", status, 8'hB2);
    wp_n = 1;
    cmd_sts_wr = 1; sts_wdata = 8'h0C; #0.5;
    chk("R8 pin high allows", {7'd0, sts_grant}, 8'd1);
    tick();
    cyc_start = 1; tick();
    cyc_end = 1; cmd_wen_set = 1; tick();
    chk("R5 set wins at end, R10 commit", status, 8'h3E);
    wp_n = 0;
    cmd_sts_wr = 1; sts_wdata = 8'h00; #0.5;
    chk("R8 unlocked pin ignored", {7'd0, sts_grant}, 8'd1);
    tick();
    cyc_start = 1; tick();
    cyc_end = 1; cmd_wen_clr = 1; nv_ld = 1; nv_ld_lock = 0; nv_ld_zone = 2'b01; tick();
    chk("R11 load beats commit, R5 clr at end", status, 8'h34);
    wp_n = 1;
    repeat (4) tick();
    summary();
  end
endmodule